// File: doc/BRIEF.md
# Network Device Control Register Bank

This block is the host-visible register bank of a network interface. A narrow request bus carries an offset, an access size in bytes, a direction and write data. Every request is checked against a fixed attribute per 4-byte slot: whether the slot exists, whether it holds a 4-byte or an 8-byte register, and whether it may be read, written, or both. A request that fails any check is answered with an error flag and zero data, and it changes nothing.

Accepted requests update the control registers and raise one-cycle strobes for the logic around the bank. Writing a receive or transmit descriptor raises a post strobe. Writing the command register with its reset bit reloads the whole bank. Reading the interrupt status raises a clear strobe and empties the status register. The receive and transmit completion words are 64-bit values built at read time. They combine the stored busy, complete and copy-length state with the live packet counts and the transmit FIFO level comparisons. All responses come back one clock after the request.

Top module: `nic_regbank`

## Requirements
- R1: Valid offsets are the multiples of 4 below 0x68. The 4-byte slots are 0x00 to 0x2C, except 0x1C. The 8-byte registers sit at 0x30, 0x38, 0x40, 0x48, 0x50, 0x58 and 0x60. Offset 0x1C, the upper half of each 8-byte register, unaligned offsets and offsets at or above 0x68 give `rsp_err`=1.
- R2: A request whose byte count is not the register's size (4 or 8) is rejected with `rsp_err`=1.
- R3: Command (0x04) is write-only. The registers 0x10-0x2C, the completion words (0x38, 0x50), the wait words (0x40, 0x58) and the address (0x60) are read-only. Config (0x00), status (0x08), mask (0x0C) and the descriptors (0x30, 0x48) are read/write. A rejected request returns zero data, raises no strobe and leaves every register unchanged.
- R4: Each request is answered with `rsp_valid`=1 exactly one cycle later. A 4-byte read returns the register zero-extended to 64 bits, and a write returns zero data.
- R5: After reset, config holds only bit 8, copied from `thread_en_i`. The mask holds `MASK_INIT` (0x8A). Status, descriptors and completion state are zero. The limit, size and mark registers hold their `init_*` inputs, and 0x60 holds `mac_i`.
- R6: A write of command with bit 0 set reloads the reset state of R5 and pulses `soft_rst_o`. A command write with bit 0 clear has no effect.
- R7: Status bits are set by `intr_set_i`. A status write clears the bits written as 1. A status read returns the value and then clears it, pulsing `istat_clr_o`. Set bits arriving in the clearing cycle survive.
- R8: A descriptor write stores the 64-bit value and sets its completion state to busy only, with complete and length cleared. It pulses `rx_post_o` (0x30) or `tx_post_o` (0x48).
- R9: A completion pulse (`rx_cpl_i`/`tx_cpl_i`) clears busy, sets complete and stores the 20-bit copy length.
- R10: Completion word layout: bits 47:32 packet count, bit 31 busy, bit 30 complete, bits 19:0 copy length, all other bits zero.
- R11: In the transmit word, bit 29 is set when `tx_free_i` is less than the tx max copy (0x14). Bit 28 is set when `tx_occ_i` is less than the tx mark (0x2C). The receive word has bits 29:28 at zero.
- R12: The wait words (0x40, 0x58) read the same as their completion words.
- R13: Config and mask read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data |
| thread_en_i | input | 1 | Reset value of config bit 8 |
| init_rx_max_copy | input | 32 | Reset value of 0x10 |
| init_tx_max_copy | input | 32 | Reset value of 0x14 |
| init_rx_max_intr | input | 32 | Reset value of 0x18 |
| init_rx_fifo_size | input | 32 | Reset value of 0x20 |
| init_tx_fifo_size | input | 32 | Reset value of 0x24 |
| init_rx_mark | input | 32 | Reset value of 0x28 |
| init_tx_mark | input | 32 | Reset value of 0x2C |
| mac_i | input | 48 | Reset value of 0x60 |
| rx_pkts_i | input | 16 | Live receive FIFO packet count |
| tx_pkts_i | input | 16 | Live transmit FIFO packet count |
| tx_free_i | input | 32 | Live transmit FIFO free bytes |
| tx_occ_i | input | 32 | Live transmit FIFO occupied bytes |
| intr_set_i | input | 8 | Interrupt status set pulses |
| rx_cpl_i | input | 1 | Receive copy finished |
| rx_cpl_len_i | input | 20 | Receive copy length |
| tx_cpl_i | input | 1 | Transmit copy finished |
| tx_cpl_len_i | input | 20 | Transmit copy length |
| cfg_o | output | 32 | Current config |
| rx_desc_o | output | 64 | Current receive descriptor |
| tx_desc_o | output | 64 | Current transmit descriptor |
| rx_post_o | output | 1 | Receive descriptor written |
| tx_post_o | output | 1 | Transmit descriptor written |
| soft_rst_o | output | 1 | Command reset taken |
| istat_clr_o | output | 1 | Status read and cleared |

## Verification
The hardest case to reach from the ports is a completion word that mixes all of its sources in one read. That needs stored busy or complete state, live packet counts, and transmit level comparisons sitting right at their limits. The stimulus posts a descriptor, holds the packet counts at nonzero values, then steps `tx_free_i` and `tx_occ_i` to one below and exactly at the thresholds. Each step is followed by a completion pulse and a read. A command reset taken after all of this shows that the stored fields clear while the live count still shows through.

// File: rtl/nic_regbank_pkg.sv
package nic_regbank_pkg;

  localparam int unsigned SLOT_W = 5;

  typedef struct packed {
    logic valid;
    logic wide;
    logic rd_ok;
    logic wr_ok;
  } reg_attr_t;

  localparam logic [SLOT_W-1:0] SL_CFG    = 5'd0;
  localparam logic [SLOT_W-1:0] SL_CMD    = 5'd1;
  localparam logic [SLOT_W-1:0] SL_ISTAT  = 5'd2;
  localparam logic [SLOT_W-1:0] SL_IMASK  = 5'd3;
  localparam logic [SLOT_W-1:0] SL_RXMC   = 5'd4;
  localparam logic [SLOT_W-1:0] SL_TXMC   = 5'd5;
  localparam logic [SLOT_W-1:0] SL_RXMI   = 5'd6;
  localparam logic [SLOT_W-1:0] SL_RXFS   = 5'd8;
  localparam logic [SLOT_W-1:0] SL_TXFS   = 5'd9;
  localparam logic [SLOT_W-1:0] SL_RXMK   = 5'd10;
  localparam logic [SLOT_W-1:0] SL_TXMK   = 5'd11;
  localparam logic [SLOT_W-1:0] SL_RXDESC = 5'd12;
  localparam logic [SLOT_W-1:0] SL_RXDONE = 5'd14;
  localparam logic [SLOT_W-1:0] SL_RXWAIT = 5'd16;
  localparam logic [SLOT_W-1:0] SL_TXDESC = 5'd18;
  localparam logic [SLOT_W-1:0] SL_TXDONE = 5'd20;
  localparam logic [SLOT_W-1:0] SL_TXWAIT = 5'd22;
  localparam logic [SLOT_W-1:0] SL_MAC    = 5'd24;

  function automatic reg_attr_t slot_attr(input logic [SLOT_W-1:0] s);
    reg_attr_t a;
    a = '0;
    case (s)
      SL_CFG, SL_ISTAT, SL_IMASK:
        a = '{valid: 1'b1, wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b1};
      SL_CMD:
        a = '{valid: 1'b1, wide: 1'b0, rd_ok: 1'b0, wr_ok: 1'b1};
      SL_RXMC, SL_TXMC, SL_RXMI, SL_RXFS, SL_TXFS, SL_RXMK, SL_TXMK:
        a = '{valid: 1'b1, wide: 1'b0, rd_ok: 1'b1, wr_ok: 1'b0};
      SL_RXDESC, SL_TXDESC:
        a = '{valid: 1'b1, wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b1};
      SL_RXDONE, SL_RXWAIT, SL_TXDONE, SL_TXWAIT, SL_MAC:
        a = '{valid: 1'b1, wide: 1'b1, rd_ok: 1'b1, wr_ok: 1'b0};
      default: a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/nic_reg_decode.sv
module nic_reg_decode
  import nic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned SPAN   = 104
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bytes,
  input  logic              write,
  output logic [SLOT_W-1:0] slot,
  output logic              bad
);
  localparam logic [3:0] NARROW_B = 4'd4;
  localparam logic [3:0] WIDE_B   = 4'd8;

  reg_attr_t  attr;
  logic       in_span;
  logic       aligned;
  logic       size_ok;
  logic       dir_ok;

  always_comb begin
    slot    = SLOT_W'(addr[ADDR_W-1:2]);
    attr    = slot_attr(slot);
    in_span = addr < ADDR_W'(SPAN);
    aligned = (addr[1:0] == 2'b00);
    size_ok = (bytes == (attr.wide ? WIDE_B : NARROW_B));
    dir_ok  = write ? attr.wr_ok : attr.rd_ok;
    bad     = !(in_span && aligned && attr.valid && size_ok && dir_ok);
  end
endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  input  logic         rdclr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] keep;

  always_comb keep = rdclr_i ? '0 : (q_o & ~w1c_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= keep | set_i;
  end

  // R7: after a read-clear only the bits set in that same cycle remain
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    rdclr_i |=> (q_o == $past(set_i)));
endmodule

// File: rtl/nic_done_track.sv
module nic_done_track #(
  parameter int unsigned PKT_W  = 16,
  parameter int unsigned LEN_W  = 20,
  parameter int unsigned WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_i,
  input  logic              cpl_i,
  input  logic [LEN_W-1:0]  cpl_len_i,
  input  logic [PKT_W-1:0]  pkts_i,
  input  logic [1:0]        lvl_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned PKT_LSB  = WORD_W / 2;
  localparam int unsigned BUSY_BIT = PKT_LSB - 1;
  localparam int unsigned CPL_BIT  = PKT_LSB - 2;
  localparam int unsigned LVL_LSB  = PKT_LSB - 4;

  logic             busy_q;
  logic             cpl_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cpl_q  <= 1'b0;
      len_q  <= '0;
    end else if (post_i) begin
      busy_q <= 1'b1;
      cpl_q  <= 1'b0;
      len_q  <= '0;
    end else if (cpl_i) begin
      busy_q <= 1'b0;
      cpl_q  <= 1'b1;
      len_q  <= cpl_len_i;
    end
  end

  always_comb begin
    word_o = '0;
    word_o[PKT_LSB +: PKT_W]  = pkts_i;
    word_o[BUSY_BIT]          = busy_q;
    word_o[CPL_BIT]           = cpl_q;
    word_o[LVL_LSB +: 2]      = lvl_i;
    word_o[LEN_W-1:0]         = len_q;
  end

  // R8: a post leaves only busy set
  a_r8_post_busy_only: assert property (@(posedge clk) disable iff (rst)
    post_i |=> (busy_q && !cpl_q && len_q == '0));
  // R9: a completion clears busy and captures the length
  a_r9_cpl_capture: assert property (@(posedge clk) disable iff (rst)
    (cpl_i && !post_i) |=> (!busy_q && cpl_q && len_q == $past(cpl_len_i)));
endmodule

// File: rtl/nic_regbank.sv
module nic_regbank
  import nic_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned SPAN       = 104,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned MAC_W      = 48,
  parameter int unsigned PKT_W      = 16,
  parameter int unsigned LEN_W      = 20,
  parameter int unsigned INTR_W     = 8,
  parameter int unsigned THREAD_BIT = 8,
  parameter logic [31:0] MASK_INIT  = 32'h0000_008A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  input  logic              thread_en_i,
  input  logic [REG_W-1:0]  init_rx_max_copy,
  input  logic [REG_W-1:0]  init_tx_max_copy,
  input  logic [REG_W-1:0]  init_rx_max_intr,
  input  logic [REG_W-1:0]  init_rx_fifo_size,
  input  logic [REG_W-1:0]  init_tx_fifo_size,
  input  logic [REG_W-1:0]  init_rx_mark,
  input  logic [REG_W-1:0]  init_tx_mark,
  input  logic [MAC_W-1:0]  mac_i,
  input  logic [PKT_W-1:0]  rx_pkts_i,
  input  logic [PKT_W-1:0]  tx_pkts_i,
  input  logic [REG_W-1:0]  tx_free_i,
  input  logic [REG_W-1:0]  tx_occ_i,
  input  logic [INTR_W-1:0] intr_set_i,
  input  logic              rx_cpl_i,
  input  logic [LEN_W-1:0]  rx_cpl_len_i,
  input  logic              tx_cpl_i,
  input  logic [LEN_W-1:0]  tx_cpl_len_i,
  output logic [REG_W-1:0]  cfg_o,
  output logic [63:0]       rx_desc_o,
  output logic [63:0]       tx_desc_o,
  output logic              rx_post_o,
  output logic              tx_post_o,
  output logic              soft_rst_o,
  output logic              istat_clr_o
);
  localparam int unsigned WORD_W = 2 * REG_W;
  localparam int unsigned NDIR   = 2;
  localparam logic [REG_W-1:0] CFG_RST = REG_W'(1) << THREAD_BIT;

  logic [SLOT_W-1:0] slot;
  logic              bad;
  logic              acc, wr_acc, rd_acc;
  logic              cmd_rst, dev_rst;
  logic              istat_rd;
  logic [INTR_W-1:0] istat_w1c;
  logic [INTR_W-1:0] istat_q;

  logic [REG_W-1:0]  mask_q;
  logic [REG_W-1:0]  rx_max_copy_q, tx_max_copy_q, rx_max_intr_q;
  logic [REG_W-1:0]  rx_fifo_size_q, tx_fifo_size_q, rx_mark_q, tx_mark_q;
  logic [MAC_W-1:0]  mac_q;
  logic [WORD_W-1:0] rd_mux;

  logic [NDIR-1:0]              post;
  logic [NDIR-1:0]              cpl;
  logic [NDIR-1:0][LEN_W-1:0]   cpl_len;
  logic [NDIR-1:0][PKT_W-1:0]   pkts;
  logic [NDIR-1:0][1:0]         lvl;
  logic [NDIR-1:0][WORD_W-1:0]  done_word;

  nic_reg_decode #(.ADDR_W(ADDR_W), .SPAN(SPAN)) u_dec (
    .addr(req_addr), .bytes(req_bytes), .write(req_write),
    .slot(slot), .bad(bad)
  );

  always_comb begin
    acc       = req_valid && !bad;
    wr_acc    = acc && req_write;
    rd_acc    = acc && !req_write;
    cmd_rst   = wr_acc && (slot == SL_CMD) && req_wdata[0];
    dev_rst   = rst || cmd_rst;
    istat_rd  = rd_acc && (slot == SL_ISTAT);
    istat_w1c = (wr_acc && slot == SL_ISTAT) ? req_wdata[INTR_W-1:0] : '0;
    post[0]   = wr_acc && (slot == SL_RXDESC);
    post[1]   = wr_acc && (slot == SL_TXDESC);
    cpl[0]    = rx_cpl_i;
    cpl[1]    = tx_cpl_i;
    cpl_len[0] = rx_cpl_len_i;
    cpl_len[1] = tx_cpl_len_i;
    pkts[0]   = rx_pkts_i;
    pkts[1]   = tx_pkts_i;
    lvl[0]    = 2'b00;
    lvl[1]    = {tx_free_i < tx_max_copy_q, tx_occ_i < tx_mark_q};
  end

  nic_irq_status #(.W(INTR_W)) u_istat (
    .clk(clk), .rst(dev_rst), .set_i(intr_set_i), .w1c_i(istat_w1c),
    .rdclr_i(istat_rd), .q_o(istat_q)
  );

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    nic_done_track #(.PKT_W(PKT_W), .LEN_W(LEN_W), .WORD_W(WORD_W)) u_done (
      .clk(clk), .rst(dev_rst), .post_i(post[g]), .cpl_i(cpl[g]),
      .cpl_len_i(cpl_len[g]), .pkts_i(pkts[g]), .lvl_i(lvl[g]),
      .word_o(done_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (dev_rst) begin
      cfg_o          <= CFG_RST & {REG_W{thread_en_i}};
      mask_q         <= MASK_INIT[REG_W-1:0];
      rx_desc_o      <= '0;
      tx_desc_o      <= '0;
      rx_max_copy_q  <= init_rx_max_copy;
      tx_max_copy_q  <= init_tx_max_copy;
      rx_max_intr_q  <= init_rx_max_intr;
      rx_fifo_size_q <= init_rx_fifo_size;
      tx_fifo_size_q <= init_tx_fifo_size;
      rx_mark_q      <= init_rx_mark;
      tx_mark_q      <= init_tx_mark;
      mac_q          <= mac_i;
    end else if (wr_acc) begin
      case (slot)
        SL_CFG:    cfg_o     <= req_wdata[REG_W-1:0];
        SL_IMASK:  mask_q    <= req_wdata[REG_W-1:0];
        SL_RXDESC: rx_desc_o <= req_wdata;
        SL_TXDESC: tx_desc_o <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      SL_CFG:                rd_mux = WORD_W'(cfg_o);
      SL_ISTAT:              rd_mux = WORD_W'(istat_q);
      SL_IMASK:              rd_mux = WORD_W'(mask_q);
      SL_RXMC:               rd_mux = WORD_W'(rx_max_copy_q);
      SL_TXMC:               rd_mux = WORD_W'(tx_max_copy_q);
      SL_RXMI:               rd_mux = WORD_W'(rx_max_intr_q);
      SL_RXFS:               rd_mux = WORD_W'(rx_fifo_size_q);
      SL_TXFS:               rd_mux = WORD_W'(tx_fifo_size_q);
      SL_RXMK:               rd_mux = WORD_W'(rx_mark_q);
      SL_TXMK:               rd_mux = WORD_W'(tx_mark_q);
      SL_RXDESC:             rd_mux = rx_desc_o;
      SL_TXDESC:             rd_mux = tx_desc_o;
      SL_RXDONE, SL_RXWAIT:  rd_mux = done_word[0];
      SL_TXDONE, SL_TXWAIT:  rd_mux = done_word[1];
      SL_MAC:                rd_mux = WORD_W'(mac_q);
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
      rx_post_o   <= 1'b0;
      tx_post_o   <= 1'b0;
      soft_rst_o  <= 1'b0;
      istat_clr_o <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_err     <= req_valid && bad;
      rsp_rdata   <= rd_acc ? rd_mux : '0;
      rx_post_o   <= post[0];
      tx_post_o   <= post[1];
      soft_rst_o  <= cmd_rst;
      istat_clr_o <= istat_rd;
    end
  end

  // R3: a rejected request yields zero data and no strobe
  a_r3_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && !rx_post_o && !tx_post_o
                                && !soft_rst_o && !istat_clr_o));
  // R4: every request is answered on the next cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R4: a single request raises at most one strobe
  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_post_o, tx_post_o, soft_rst_o, istat_clr_o}));
  // R6: a command reset leaves config and descriptors at reset values
  a_r6_soft_reset_state: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> (cfg_o == (CFG_RST & {REG_W{thread_en_i}})
                    && rx_desc_o == '0 && tx_desc_o == '0));
endmodule

// File: tb/nic_regbank_test.sv
module nic_regbank_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 20000;

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [3:0]  bytes;
    logic [63:0] wdata;
    logic        err;
    logic [63:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 7'h00, 4'd4, 64'h0, 1'b0, 64'h100,          8'd5},  // R5 config thread bit
    '{1'b0, 7'h0C, 4'd4, 64'h0, 1'b0, 64'h8A,           8'd5},  // R5 mask init
    '{1'b0, 7'h10, 4'd4, 64'h0, 1'b0, 64'h5EA,          8'd5},  // R5 rx max copy
    '{1'b0, 7'h18, 4'd4, 64'h0, 1'b0, 64'd10,           8'd5},  // R5 rx max intr
    '{1'b0, 7'h60, 4'd8, 64'h0, 1'b0, 64'h0012_3456_789A, 8'd5},// R5 mac
    '{1'b0, 7'h1C, 4'd4, 64'h0, 1'b1, 64'h0,            8'd1},  // R1 reserved slot
    '{1'b0, 7'h34, 4'd4, 64'h0, 1'b1, 64'h0,            8'd1},  // R1 upper half
    '{1'b0, 7'h68, 4'd8, 64'h0, 1'b1, 64'h0,            8'd1},  // R1 past span
    '{1'b0, 7'h02, 4'd4, 64'h0, 1'b1, 64'h0,            8'd1},  // R1 unaligned
    '{1'b0, 7'h10, 4'd8, 64'h0, 1'b1, 64'h0,            8'd2},  // R2 wide on narrow
    '{1'b1, 7'h30, 4'd4, 64'h5, 1'b1, 64'h0,            8'd2},  // R2 narrow on wide
    '{1'b0, 7'h04, 4'd4, 64'h0, 1'b1, 64'h0,            8'd3},  // R3 read write-only
    '{1'b1, 7'h10, 4'd4, 64'h5, 1'b1, 64'h0,            8'd3},  // R3 write read-only
    '{1'b0, 7'h10, 4'd4, 64'h0, 1'b0, 64'h5EA,          8'd3},  // R3 unchanged
    '{1'b1, 7'h00, 4'd4, 64'h7, 1'b0, 64'h0,            8'd4},  // R4 write gives zero
    '{1'b0, 7'h00, 4'd4, 64'h0, 1'b0, 64'h7,            8'd13}, // R13 config back
    '{1'b1, 7'h0C, 4'd4, 64'hFF, 1'b0, 64'h0,           8'd13},
    '{1'b0, 7'h0C, 4'd4, 64'h0, 1'b0, 64'hFF,           8'd13}, // R13 mask back
    '{1'b0, 7'h50, 4'd8, 64'h0, 1'b0, 64'h1000_0000,    8'd11}, // R11 low only
    '{1'b0, 7'h58, 4'd8, 64'h0, 1'b0, 64'h1000_0000,    8'd12}, // R12 wait = done
    '{1'b0, 7'h38, 4'd8, 64'h0, 1'b0, 64'h0,            8'd10}  // R10 idle rx word
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [3:0]  req_bytes = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [15:0] rx_pkts = '0, tx_pkts = '0;
  logic [31:0] tx_free = 32'h1_0000, tx_occ = '0;
  logic [7:0]  intr_set = '0;
  logic        rx_cpl = 1'b0, tx_cpl = 1'b0;
  logic [19:0] rx_len = '0, tx_len = '0;
  logic [31:0] cfg;
  logic [63:0] rx_desc, tx_desc;
  logic        rx_post, tx_post, soft_rst, istat_clr;

  int checks = 0;
  int errors = 0;
  logic        r_err;
  logic [63:0] r_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nic_regbank uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .thread_en_i(1'b1),
    .init_rx_max_copy(32'h5EA), .init_tx_max_copy(32'h4000),
    .init_rx_max_intr(32'd10), .init_rx_fifo_size(32'h1_0000),
    .init_tx_fifo_size(32'h1_0000), .init_rx_mark(32'hC000),
    .init_tx_mark(32'h4000), .mac_i(48'h0012_3456_789A),
    .rx_pkts_i(rx_pkts), .tx_pkts_i(tx_pkts), .tx_free_i(tx_free),
    .tx_occ_i(tx_occ), .intr_set_i(intr_set),
    .rx_cpl_i(rx_cpl), .rx_cpl_len_i(rx_len),
    .tx_cpl_i(tx_cpl), .tx_cpl_len_i(tx_len),
    .cfg_o(cfg), .rx_desc_o(rx_desc), .tx_desc_o(tx_desc),
    .rx_post_o(rx_post), .tx_post_o(tx_post), .soft_rst_o(soft_rst),
    .istat_clr_o(istat_clr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, response sampled at the following negedge
  task automatic xfer(input logic w, input logic [6:0] a, input logic [3:0] b,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_bytes = b; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    r_err  = rsp_err;
    r_data = rsp_rdata;
    chk("R4 rsp_valid", 64'(rsp_valid), 64'd1);
  endtask

  task automatic rd(input logic [6:0] a, input logic [3:0] b, input string tag,
                    input logic [63:0] exp);
    xfer(1'b0, a, b, 64'h0);
    chk(tag, r_data, exp);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R5 / R4: quiet outputs after reset
    chk("R4 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R5 reset strobes", 64'({rx_post, tx_post, soft_rst, istat_clr}), 64'd0);
    chk("R5 reset cfg_o", 64'(cfg), 64'h100);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].bytes, VECS[i].wdata);
      checks++;
      if (r_err !== VECS[i].err || r_data !== VECS[i].rdata) begin
        errors++;
        $display("FAIL vec %0d (R%0d): actual err=%b data=%h expected err=%b data=%h",
                 i, VECS[i].req, r_err, r_data, VECS[i].err, VECS[i].rdata);
      end
    end

    // R7: status set, read-clear, write-one-to-clear
    @(negedge clk) intr_set = 8'h05;
    @(negedge clk) intr_set = 8'h00;
    rd(7'h08, 4'd4, "R7 status read", 64'h05);
    chk("R7 clear strobe", 64'(istat_clr), 64'd1);
    rd(7'h08, 4'd4, "R7 status after read", 64'h0);
    @(negedge clk) intr_set = 8'h0C;
    @(negedge clk) intr_set = 8'h00;
    xfer(1'b1, 7'h08, 4'd4, 64'h04);
    chk("R7 w1c no clear strobe", 64'(istat_clr), 64'd0);
    rd(7'h08, 4'd4, "R7 after w1c", 64'h08);

    // R8 / R10: receive descriptor post
    rx_pkts = 16'd3;
    xfer(1'b1, 7'h30, 4'd8, 64'h0000_1234_5600_0040);
    chk("R8 rx_post_o", 64'(rx_post), 64'd1);
    chk("R8 rx_desc_o", rx_desc, 64'h0000_1234_5600_0040);
    rd(7'h38, 4'd8, "R10 rx busy word", 64'h0000_0003_8000_0000);
    rd(7'h30, 4'd8, "R8 rx desc read", 64'h0000_1234_5600_0040);

    // R9 / R12: receive completion
    @(negedge clk) begin rx_cpl = 1'b1; rx_len = 20'h40; end
    @(negedge clk) rx_cpl = 1'b0;
    rd(7'h38, 4'd8, "R9 rx complete word", 64'h0000_0003_4000_0040);
    rd(7'h40, 4'd8, "R12 rx wait word", 64'h0000_0003_4000_0040);

    // R8 / R11: transmit post and level flags at the thresholds
    tx_pkts = 16'd2;
    xfer(1'b1, 7'h48, 4'd8, 64'h0000_0800_0000_1000);
    chk("R8 tx_post_o", 64'(tx_post), 64'd1);
    rd(7'h50, 4'd8, "R11 tx busy low", 64'h0000_0002_9000_0000);
    tx_free = 32'h3FFF; tx_occ = 32'h4000;
    rd(7'h50, 4'd8, "R11 tx full not low", 64'h0000_0002_A000_0000);
    tx_free = 32'h4000; tx_occ = 32'h3FFF;
    rd(7'h58, 4'd8, "R11 tx at limits", 64'h0000_0002_9000_0000);
    tx_free = 32'h1_0000; tx_occ = 32'h1_0000;
    @(negedge clk) begin tx_cpl = 1'b1; tx_len = 20'h123; end
    @(negedge clk) tx_cpl = 1'b0;
    rd(7'h50, 4'd8, "R9 tx complete word", 64'h0000_0002_4000_0123);

    // R3: rejected write leaves tx word and strobes alone
    xfer(1'b1, 7'h50, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 reject err", 64'(r_err), 64'd1);
    chk("R3 reject no post", 64'(tx_post), 64'd0);
    rd(7'h50, 4'd8, "R3 tx word unchanged", 64'h0000_0002_4000_0123);

    // R6: command without bit 0, then with it
    xfer(1'b1, 7'h04, 4'd4, 64'h2);
    chk("R6 no reset strobe", 64'(soft_rst), 64'd0);
    rd(7'h00, 4'd4, "R6 config kept", 64'h7);
    xfer(1'b1, 7'h04, 4'd4, 64'h1);
    chk("R6 reset strobe", 64'(soft_rst), 64'd1);
    rd(7'h00, 4'd4, "R6 config reloaded", 64'h100);
    rd(7'h0C, 4'd4, "R6 mask reloaded", 64'h8A);
    rd(7'h38, 4'd8, "R6 rx word cleared", 64'h0000_0003_0000_0000);
    rd(7'h30, 4'd8, "R6 rx desc cleared", 64'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule